// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the read side of a synchronous NOR-style flash device. A host selects the device with an active-low chip select, latches a word address with an address-valid strobe and reads words on `dout` while its output enable is low. A 16-bit configuration register decides how the read works. In asynchronous mode the addressed word appears on the clock edge that latches the address. In burst mode a programmable number of clock edges pass before the first word, and then one word follows on every edge. The burst address moves either linearly or wraps inside an aligned block of 8, 16 or 32 words. A ready output, whose polarity and lead time are set in the register, marks valid data. The storage array is modelled as a fixed function of the address.

The register is written through a dedicated write strobe. It keeps its value across chip-select cycles, and only the hardware reset restores its defaults. A read-back request puts the block into a view state that drives the register onto `dout`. The block stays there until a software reset pulse.

The sequencer has five states. S_IDLE waits for a strobe. S_ASYNC presents an asynchronous word. S_LAT counts the initial latency. S_BURST streams words. S_VIEW presents the register. The transitions are as follows. Chip select high moves any state other than S_VIEW to S_IDLE. A read-back request moves any state other than S_VIEW to S_VIEW. A strobe moves any state other than S_VIEW to S_LAT in burst mode or to S_ASYNC in asynchronous mode. S_LAT moves to S_BURST once the latency count is reached. S_VIEW moves to S_IDLE on a software reset.

Top module: `burst_read_engine`

## Requirements
- R1: On hardware reset the register reads back 0xAFC8. This means asynchronous mode, latency code 101, ready active high and with data, wrap on, and continuous length. After reset, and while idle, `rdy` is at its inactive level and `dout` is 0.
- R2: Register bit 15 selects the mode: 1 is asynchronous and 0 is burst. In asynchronous mode, the word for the strobed address is on `dout` right after the latching edge, and `rdy` is active. The word stored at address a is a XOR 0x5A3C.
- R3: In burst mode the latency field is bits 13:11, holding code c. For c from 0 to 5, the first word (for the start address) appears after the (c+2)th rising edge following the latching edge, and `dout` is 0 before that. Codes 6 and 7 behave like code 5. After the first word, one word follows per edge.
- R4: Register bit 10 sets the ready polarity: 1 means active high and 0 means active low. The inactive level is the complement.
- R5: Register bit 8 sets the ready lead time. With a value of 0, `rdy` goes active one edge before the first word. With a value of 1, `rdy` goes active with the first word. With latency code 000, `rdy` always goes active with the data.
- R6: With bit 3 set to 1 and length bits 2:0 set to 010, 011 or 100, successive burst addresses increment modulo 8, 16 or 32 inside the aligned block that holds the start address.
- R7: With bit 3 set to 0, or with a length code other than 010, 011 or 100, successive burst addresses increment by one modulo 2^16.
- R8: Chip select high ends any access. After the next edge `rdy` is inactive and `dout` is 0, and the register keeps its contents.
- R9: A read-back request with chip select low enters the view state on the next edge. In the view state, `dout` shows the register and `rdy` is active. Strobes are ignored until a software reset pulse, which returns the block to idle.
- R10: Bits 14, 5 and 4 always read 0, and bits 9, 7 and 6 always read 1, whatever value is written.
- R11: While `oe_n` is high, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| adr_vld | input | 1 | Address-valid strobe, latches adr_i |
| oe_n | input | 1 | Output enable, active low |
| adr_i | input | 16 | Word address |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rd | input | 1 | Configuration read-back request |
| soft_rst | input | 1 | Software reset, leaves the view state |
| dout | output | 16 | Read data |
| rdy | output | 1 | Ready, programmable polarity and lead |

## Verification
A latency counter that is off by one shifts the first word and the ready edge by a whole cycle. The bench sees this within at most seven edges of the strobe, because it samples every cycle against an edge number computed for each latency code. A wrong burst address step shows up on the first word that crosses a block boundary, which is at most 32 words into a burst. A sequencer stuck in the view state, or one that leaves it too early, shows up at once on `dout` as register contents where zero or memory data was expected. The assertions watch the register between writes, the reserved bits and the deselected outputs on every cycle.

// File: rtl/brd_pkg.sv
package brd_pkg;

    localparam int CFG_W = 16;
    localparam logic [CFG_W-1:0] CFG_RESET      = 16'hAFC8;
    localparam logic [CFG_W-1:0] CFG_FIXED_MASK = 16'h42F0;
    localparam logic [CFG_W-1:0] CFG_FIXED_VAL  = CFG_RESET & CFG_FIXED_MASK;

    localparam int MAX_EDGE = 7;
    localparam int CNT_W    = $clog2(MAX_EDGE + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ASYNC,
        S_LAT,
        S_BURST,
        S_VIEW
    } seq_state_t;

    typedef struct packed {
        logic             sync_mode;
        logic [CNT_W-1:0] edge_n;
        logic             rdy_pol;
        logic             rdy_early;
        logic             wrap;
        logic [1:0]       blk_sel;
    } cfg_dec_t;

    function automatic cfg_dec_t cfg_decode(
        input logic       mode_bit,
        input logic [2:0] lat,
        input logic       pol_bit,
        input logic       with_data_bit,
        input logic       wrap_bit,
        input logic [2:0] len
    );
        cfg_dec_t d;
        d.sync_mode = ~mode_bit;
        d.edge_n    = (lat > 3'd5) ? CNT_W'(MAX_EDGE) : CNT_W'(lat) + CNT_W'(2);
        d.rdy_pol   = pol_bit;
        d.rdy_early = ~with_data_bit & (lat != 3'd0);
        d.wrap      = wrap_bit;
        unique case (len)
            3'b010:  d.blk_sel = 2'd1;
            3'b011:  d.blk_sel = 2'd2;
            3'b100:  d.blk_sel = 2'd3;
            default: d.blk_sel = 2'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/brd_cfg_reg.sv
module brd_cfg_reg
    import brd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);

    // Reserved positions are forced to their fixed values on every write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CFG_RESET;
        end else if (we) begin
            q <= (wdata & ~CFG_FIXED_MASK) | CFG_FIXED_VAL;
        end
    end

endmodule

// File: rtl/brd_addr_step.sv
module brd_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wrap,
    input  logic [1:0]        blk_sel,
    output logic [ADDR_W-1:0] nxt
);

    localparam int N_BLK = 3;
    localparam int K_MIN = 3;

    logic [ADDR_W-1:0] cand [N_BLK];

    // One wrapped candidate per block size: 8, 16, 32 words.
    for (genvar g = 0; g < N_BLK; g++) begin : g_blk
        localparam int K = K_MIN + g;
        assign cand[g] = {cur[ADDR_W-1:K], cur[K-1:0] + K'(1)};
    end

    always_comb begin
        nxt = cur + ADDR_W'(1);
        if (wrap) begin
            unique case (blk_sel)
                2'd1:    nxt = cand[0];
                2'd2:    nxt = cand[1];
                2'd3:    nxt = cand[2];
                default: nxt = cur + ADDR_W'(1);
            endcase
        end
    end

endmodule

// File: rtl/brd_seq.sv
module brd_seq
    import brd_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] SALT   = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adr_vld,
    input  logic              cfg_rd,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic              sync_mode,
    input  logic [CNT_W-1:0]  edge_n,
    input  logic              rdy_early,
    input  logic [ADDR_W-1:0] step_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output seq_state_t        st,
    output logic [DATA_W-1:0] data_q,
    output logic              rdy_on,
    output logic              show_data,
    output logic              show_cfg
);

    seq_state_t       st_nx;
    logic [CNT_W-1:0] cnt;
    logic             live;
    logic             start;
    logic             run;
    logic             lat_done;

    function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        return DATA_W'(a) ^ SALT;
    endfunction

    assign live     = (st != S_VIEW) && !cs_n && !cfg_rd;
    assign start    = live && adr_vld;
    assign run      = live && !adr_vld;
    assign lat_done = (cnt >= edge_n);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_VIEW: begin
                if (soft_rst) st_nx = S_IDLE;
            end
            S_IDLE, S_ASYNC, S_LAT, S_BURST: begin
                if (cs_n)                        st_nx = S_IDLE;
                else if (cfg_rd)                 st_nx = S_VIEW;
                else if (adr_vld)                st_nx = sync_mode ? S_LAT : S_ASYNC;
                else if (st == S_LAT && lat_done) st_nx = S_BURST;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // Latency counter, burst address and data word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cur_addr <= '0;
            data_q   <= '0;
        end else if (start) begin
            cnt      <= CNT_W'(1);
            cur_addr <= adr_i;
            if (!sync_mode) data_q <= word_at(adr_i);
        end else if (run && st == S_LAT) begin
            if (lat_done) begin
                data_q   <= word_at(cur_addr);
                cur_addr <= step_addr;
            end else if (cnt != '1) begin
                cnt <= cnt + CNT_W'(1);
            end
        end else if (run && st == S_BURST) begin
            data_q   <= word_at(cur_addr);
            cur_addr <= step_addr;
        end
    end

    // Output decode
    always_comb begin
        rdy_on    = 1'b0;
        show_data = 1'b0;
        show_cfg  = 1'b0;
        unique case (st)
            S_ASYNC, S_BURST: begin
                rdy_on    = 1'b1;
                show_data = 1'b1;
            end
            S_LAT:  rdy_on = rdy_early && lat_done;
            S_VIEW: begin
                rdy_on   = 1'b1;
                show_cfg = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
    import brd_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] SALT   = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adr_vld,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cfg_rd,
    input  logic              soft_rst,
    output logic [DATA_W-1:0] dout,
    output logic              rdy
);

    logic [CFG_W-1:0]  cfg_q;
    cfg_dec_t          dec;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] step_addr;
    seq_state_t        st;
    logic [DATA_W-1:0] data_q;
    logic              rdy_on;
    logic              show_data;
    logic              show_cfg;

    brd_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    assign dec = cfg_decode(cfg_q[15], cfg_q[13:11], cfg_q[10], cfg_q[8],
                            cfg_q[3], cfg_q[2:0]);

    brd_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur     (cur_addr),
        .wrap    (dec.wrap),
        .blk_sel (dec.blk_sel),
        .nxt     (step_addr)
    );

    brd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SALT(SALT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .adr_vld   (adr_vld),
        .cfg_rd    (cfg_rd),
        .soft_rst  (soft_rst),
        .adr_i     (adr_i),
        .sync_mode (dec.sync_mode),
        .edge_n    (dec.edge_n),
        .rdy_early (dec.rdy_early),
        .step_addr (step_addr),
        .cur_addr  (cur_addr),
        .st        (st),
        .data_q    (data_q),
        .rdy_on    (rdy_on),
        .show_data (show_data),
        .show_cfg  (show_cfg)
    );

    always_comb begin
        dout = '0;
        if (!oe_n) begin
            if (show_cfg)       dout = DATA_W'(cfg_q);
            else if (show_data) dout = data_q;
        end
    end

    assign rdy = rdy_on ? dec.rdy_pol : ~dec.rdy_pol;

endmodule

// File: rtl/brd_chk.sv
module brd_chk
    import brd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              cfg_we,
    input logic              soft_rst,
    input logic [DATA_W-1:0] dout,
    input logic              rdy,
    input logic [CFG_W-1:0]  cfg_q,
    input seq_state_t        st
);

    // R8: without a write strobe the register holds its value
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    // R10: reserved positions never leave their fixed values
    p_rsv_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q & CFG_FIXED_MASK) == CFG_FIXED_VAL);

    // R9: the view state is kept until a software reset
    p_view_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_VIEW && !soft_rst) |=> (st == S_VIEW));

    // R8: a deselect outside the view state quiets both outputs
    p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && st != S_VIEW) |=> (rdy != cfg_q[10] && dout == '0));

    // R11: output enable high forces zero data
    p_oe_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> dout == '0);

    // R2: an asynchronous word is always marked ready
    p_async_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ASYNC) |-> (rdy == cfg_q[10]));

endmodule

bind burst_read_engine brd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .cfg_we   (cfg_we),
    .soft_rst (soft_rst),
    .dout     (dout),
    .rdy      (rdy),
    .cfg_q    (cfg_q),
    .st       (st)
);

// File: tb/burst_read_engine_test.sv
module burst_read_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        adr_vld = 1'b0;
    logic        oe_n = 1'b1;
    logic [15:0] adr_i = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_rd = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] dout;
    logic        rdy;

    int total = 0;
    int bad = 0;

    burst_read_engine uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adr_vld(adr_vld), .oe_n(oe_n),
        .adr_i(adr_i), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
        .soft_rst(soft_rst), .dout(dout), .rdy(rdy)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] exp_step(input logic [15:0] a, input logic wrap,
                                             input logic [2:0] len);
        int k;
        logic [15:0] m;
        k = (len == 3'd2) ? 3 : (len == 3'd3) ? 4 : (len == 3'd4) ? 5 : 0;
        if (wrap && k != 0) begin
            m = (16'd1 << k) - 16'd1;
            return (a & ~m) | ((a + 16'd1) & m);
        end
        return a + 16'd1;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic readback(output logic [15:0] v);
        cs_n = 1'b0;
        oe_n = 1'b0;
        cfg_rd = 1'b1;
        tick();
        cfg_rd = 1'b0;
        v = dout;
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        cs_n = 1'b1;
        tick();
    endtask

    task automatic start(input logic [15:0] a);
        cs_n = 1'b0;
        oe_n = 1'b0;
        adr_vld = 1'b1;
        adr_i = a;
        tick();
        adr_vld = 1'b0;
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 idle rdy", {15'd0, rdy}, 16'd0);
        check("R1 idle dout", dout, 16'd0);
        readback(v);
        check("R1 reset value", v, 16'hAFC8);
    endtask

    task automatic t_async();
        start(16'h0123);
        check("R2 async word", dout, mem_word(16'h0123));
        check("R2 async rdy", {15'd0, rdy}, 16'd1);
        adr_vld = 1'b1;
        adr_i = 16'h0456;
        tick();
        adr_vld = 1'b0;
        check("R2 async restrobe", dout, mem_word(16'h0456));
        deselect();
    endtask

    // R3 R4 R5: first-word edge and ready waveform for every latency/lead/polarity
    task automatic t_latency();
        for (int code = 0; code < 8; code++) begin
            for (int tim = 0; tim < 2; tim++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    int n;
                    logic early;
                    logic [15:0] cfg;
                    cfg = {2'b00, 3'(code), 1'(pol), 1'b1, 1'(tim), 8'hC8};
                    n = (code < 6) ? code + 2 : 7;
                    early = (tim == 0) && (code != 0);
                    wr_cfg(cfg);
                    start(16'h0040);
                    for (int k = 1; k <= n + 3; k++) begin
                        logic act;
                        tick();
                        act = (k >= n) || (early && k >= n - 1);
                        check($sformatf("R3 dout code=%0d k=%0d", code, k), dout,
                              (k >= n) ? mem_word(16'h0040 + 16'(k - n)) : 16'd0);
                        check($sformatf("R5 R4 rdy code=%0d tim=%0d pol=%0d k=%0d",
                                        code, tim, pol, k),
                              {15'd0, rdy}, {15'd0, act ? 1'(pol) : ~1'(pol)});
                    end
                    deselect();
                end
            end
        end
    endtask

    task automatic t_order_one(input logic wrap, input logic [2:0] len,
                               input logic [15:0] a0, input string tag);
        logic [15:0] a;
        wr_cfg({2'b00, 3'b000, 1'b1, 1'b1, 1'b1, 4'b1100, wrap, len});
        start(a0);
        tick();
        a = a0;
        for (int i = 0; i < 40; i++) begin
            tick();
            check($sformatf("%s word %0d", tag, i), dout, mem_word(a));
            a = exp_step(a, wrap, len);
        end
        deselect();
    endtask

    task automatic t_order();
        t_order_one(1'b1, 3'b010, 16'h1236, "R6 wrap8");
        t_order_one(1'b1, 3'b011, 16'h123B, "R6 wrap16");
        t_order_one(1'b1, 3'b100, 16'h1236, "R6 wrap32");
        t_order_one(1'b0, 3'b010, 16'h1236, "R7 nowrap8");
        t_order_one(1'b0, 3'b100, 16'h1236, "R7 nowrap32");
        t_order_one(1'b1, 3'b000, 16'hFFEC, "R7 continuous rollover");
        t_order_one(1'b1, 3'b101, 16'h1236, "R7 reserved length");
    endtask

    task automatic t_deselect();
        logic [15:0] v;
        wr_cfg(16'h07CA);
        start(16'h0200);
        repeat (4) tick();
        cs_n = 1'b1;
        tick();
        check("R8 rdy after deselect", {15'd0, rdy}, 16'd0);
        check("R8 dout after deselect", dout, 16'd0);
        readback(v);
        check("R8 cfg kept", v, 16'h07CA);
    endtask

    task automatic t_oe();
        wr_cfg(16'h07C8);
        start(16'h0300);
        repeat (3) tick();
        oe_n = 1'b1;
        tick();
        check("R11 dout oe high", dout, 16'd0);
        check("R11 rdy still active", {15'd0, rdy}, 16'd1);
        oe_n = 1'b0;
        tick();
        check("R11 dout resumes", dout, mem_word(16'h0303));
        deselect();
    endtask

    task automatic t_view();
        cs_n = 1'b0;
        oe_n = 1'b0;
        cfg_rd = 1'b1;
        tick();
        cfg_rd = 1'b0;
        check("R9 view shows cfg", dout, 16'h07C8);
        check("R9 view rdy", {15'd0, rdy}, 16'd1);
        adr_vld = 1'b1;
        adr_i = 16'h0500;
        repeat (3) tick();
        adr_vld = 1'b0;
        cs_n = 1'b1;
        tick();
        cs_n = 1'b0;
        check("R9 strobe ignored", dout, 16'h07C8);
        oe_n = 1'b1;
        tick();
        check("R11 view oe high", dout, 16'd0);
        oe_n = 1'b0;
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        check("R9 soft reset dout", dout, 16'd0);
        check("R9 soft reset rdy", {15'd0, rdy}, 16'd0);
        deselect();
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr_cfg(16'h0000);
        readback(v);
        check("R10 write zeros", v, 16'h02C0);
        wr_cfg(16'hFFFF);
        readback(v);
        check("R10 write ones", v, 16'hBFCF);
    endtask

    task automatic t_hw_reset();
        logic [15:0] v;
        wr_cfg(16'h0000);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        readback(v);
        check("R1 reset restores", v, 16'hAFC8);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_async();
        t_latency();
        t_order();
        t_deselect();
        t_oe();
        t_view();
        t_reserved();
        t_hw_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule